// File: doc/BRIEF.md
# Readout Card Bus Slave Decoder

This block sits on the slave side of a VME readout card that holds a data FIFO and a running word count. On every bus cycle it compares the address, the address-modifier code, the data-width flag and the direction against the card's own windows. It then picks one of three resources, answers with read data and an acknowledge, or stays silent. The FIFO storage lives outside the block and is reached through a pop strobe, a head-of-queue data input and a push strobe.

The card uses a split address map. The word count is read in A16 short I/O space as a 16-bit quantity. The FIFO data port and a control register are reached in A24 space as 32-bit quantities. Each card owns a 2 KB window in each space. The window position is the switch setting plus the backplane slot number, both counted in 2 KB units, so cards in adjacent slots occupy adjacent windows. Nothing is decoded in A32 space.

Top module: `rdo_addr_dec`

## Requirements
- R1: An A24 access targets this card only when address bits [23:11] equal (sw_a24_i + slot_i) modulo 2^13. An A16 access targets it only when address bits [15:11] equal (sw_a16_i + slot_i) modulo 32. An access anywhere else gets no acknowledge.
- R2: A read with modifier 0x2D, lword_i low, at window offset 0x000 of the A16 window returns the word count in rdata_o[15:0], with bits [31:16] zero. The returned value is the count as it stood before that cycle's push or pop.
- R3: A read with modifier 0x39 or 0x3D, lword_i high, at offset 0x000 of the A24 window returns the FIFO head word on rdata_o. It pulses fifo_pop_o for exactly one clock, so each acknowledged read pops once. When the FIFO is empty the read is still acknowledged, returns zero and does not pop.
- R4: A 32-bit access with modifier 0x39 or 0x3D at offset 0x004 of the A24 window reads or writes the control register. The register drives ctrl_o and resets to zero.
- R5: Any other modifier code, including A32 codes and A16 codes aimed at the data region, gets no acknowledge and changes no state.
- R6: A width mismatch, a write to the word count or the FIFO port, or any unmapped offset gets no acknowledge and changes no state.
- R7: The word count equals pushes minus pops. A push and a pop in the same clock leave it unchanged.
- R8: ack_o rises on the first clock edge at which strobe_i is high and the access hits. It stays high while strobe_i stays high and falls on the first edge at which strobe_i is low. One strobe performs one action.
- R9: After reset, ack_o and fifo_pop_o are low, the word count is zero and ctrl_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sw_a24_i | input | 13 | Switch base for A24 window, 2 KB units |
| sw_a16_i | input | 5 | Switch base for A16 window, 2 KB units |
| slot_i | input | 4 | Backplane slot number |
| addr_i | input | 24 | Bus byte address |
| am_i | input | 6 | Address-modifier code |
| strobe_i | input | 1 | Access strobe, high for the whole cycle |
| write_i | input | 1 | High for write, low for read |
| lword_i | input | 1 | High for 32-bit access, low for 16-bit |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid while ack_o is high |
| ack_o | output | 1 | Access acknowledge |
| fifo_push_i | input | 1 | A word entered the FIFO this clock |
| fifo_data_i | input | 32 | FIFO head word |
| fifo_pop_o | output | 1 | Remove the FIFO head word |
| ctrl_o | output | 32 | Control register contents |

## Verification
Two things can land on the same clock edge: a push from the front end and a pop from an acknowledged FIFO read. A push can also land on the edge where the word count is sampled for an A16 read. The bench raises fifo_push_i in exactly the cycle its strobe first goes high, so the push and the decode meet on one edge. It then judges the outcome by reading the count back over A16 and expecting it unchanged after a push-plus-pop. For the read that coincides with a push, it expects the value from before the push. A behavioural queue model runs alongside and is compared every clock.

// File: rtl/rdo_pkg.sv
package rdo_pkg;
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_WCNT = 2'd1,
    TGT_FIFO = 2'd2,
    TGT_CTRL = 2'd3
  } tgt_e;

  localparam logic [5:0] AM_SHORT_SUP = 6'h2D;
  localparam logic [5:0] AM_STD_USR   = 6'h39;
  localparam logic [5:0] AM_STD_SUP   = 6'h3D;
endpackage

// File: rtl/rdo_win_match.sv
module rdo_win_match #(
  parameter int SPACE_W = 24,
  parameter int WIN_W   = 11,
  parameter int SLOT_W  = 4,
  localparam int HI_W   = SPACE_W - WIN_W
) (
  input  logic [HI_W-1:0]   addr_hi_i,
  input  logic [HI_W-1:0]   sw_i,
  input  logic [SLOT_W-1:0] slot_i,
  output logic              match_o
);
  logic [HI_W-1:0] card_base;

  // slot offset adds whole windows, wrapping within the space
  assign card_base = sw_i + HI_W'(slot_i);
  assign match_o   = (addr_hi_i == card_base);
endmodule

// File: rtl/rdo_decode.sv
module rdo_decode
  import rdo_pkg::*;
#(
  parameter int              WIN_W    = 11,
  parameter logic [WIN_W-1:0] FIFO_OFS = '0,
  parameter logic [WIN_W-1:0] CTRL_OFS = WIN_W'(4),
  parameter logic [WIN_W-1:0] WCNT_OFS = '0
) (
  input  logic             hit16_i,
  input  logic             hit24_i,
  input  logic [5:0]       am_i,
  input  logic [WIN_W-1:0] ofs_i,
  input  logic             write_i,
  input  logic             lword_i,
  output tgt_e             tgt_o
);
  logic am16, am24;

  assign am16 = (am_i == AM_SHORT_SUP);
  assign am24 = (am_i == AM_STD_USR) || (am_i == AM_STD_SUP);

  always_comb begin
    tgt_o = TGT_NONE;
    if (am16 && hit16_i && !lword_i && !write_i && ofs_i == WCNT_OFS)
      tgt_o = TGT_WCNT;
    else if (am24 && hit24_i && lword_i) begin
      if (ofs_i == FIFO_OFS && !write_i) tgt_o = TGT_FIFO;
      else if (ofs_i == CTRL_OFS)        tgt_o = TGT_CTRL;
    end
  end
endmodule

// File: rtl/rdo_wcount.sv
module rdo_wcount #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  output logic [CW-1:0] count_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              count_o <= '0;
    else if (push_i && !pop_i) count_o <= count_o + CW'(1);
    else if (pop_i && !push_i) count_o <= count_o - CW'(1);
  end
endmodule

// File: rtl/rdo_addr_dec.sv
module rdo_addr_dec
  import rdo_pkg::*;
#(
  parameter int AW     = 24,
  parameter int A16_W  = 16,
  parameter int WIN_W  = 11,
  parameter int SLOT_W = 4,
  parameter int DW     = 32,
  parameter int CW     = 16,
  localparam int HI24_W = AW - WIN_W,
  localparam int HI16_W = A16_W - WIN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [HI24_W-1:0] sw_a24_i,
  input  logic [HI16_W-1:0] sw_a16_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [5:0]        am_i,
  input  logic              strobe_i,
  input  logic              write_i,
  input  logic              lword_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              ack_o,
  input  logic              fifo_push_i,
  input  logic [DW-1:0]     fifo_data_i,
  output logic              fifo_pop_o,
  output logic [DW-1:0]     ctrl_o
);
  logic          hit16, hit24, take, nonempty;
  tgt_e          tgt;
  logic [CW-1:0] wcnt;

  rdo_win_match #(.SPACE_W(AW), .WIN_W(WIN_W), .SLOT_W(SLOT_W)) u_win24 (
    .addr_hi_i (addr_i[AW-1:WIN_W]),
    .sw_i      (sw_a24_i),
    .slot_i    (slot_i),
    .match_o   (hit24)
  );

  rdo_win_match #(.SPACE_W(A16_W), .WIN_W(WIN_W), .SLOT_W(SLOT_W)) u_win16 (
    .addr_hi_i (addr_i[A16_W-1:WIN_W]),
    .sw_i      (sw_a16_i),
    .slot_i    (slot_i),
    .match_o   (hit16)
  );

  rdo_decode #(.WIN_W(WIN_W)) u_dec (
    .hit16_i (hit16),
    .hit24_i (hit24),
    .am_i    (am_i),
    .ofs_i   (addr_i[WIN_W-1:0]),
    .write_i (write_i),
    .lword_i (lword_i),
    .tgt_o   (tgt)
  );

  rdo_wcount #(.CW(CW)) u_wcnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (fifo_push_i),
    .pop_i   (fifo_pop_o),
    .count_o (wcnt)
  );

  // one action per strobe: only act on the edge that raises ack
  assign take       = strobe_i && !ack_o && (tgt != TGT_NONE);
  assign nonempty   = (wcnt != '0);
  assign fifo_pop_o = take && (tgt == TGT_FIFO) && nonempty;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_o   <= 1'b0;
      rdata_o <= '0;
      ctrl_o  <= '0;
    end else begin
      if (!strobe_i) ack_o <= 1'b0;
      else if (take) ack_o <= 1'b1;
      if (take) begin
        unique case (tgt)
          TGT_WCNT: rdata_o <= DW'(wcnt);
          TGT_FIFO: rdata_o <= nonempty ? fifo_data_i : '0;
          TGT_CTRL: rdata_o <= write_i ? '0 : ctrl_o;
          default:  rdata_o <= '0;
        endcase
        if (tgt == TGT_CTRL && write_i) ctrl_o <= wdata_i;
      end
    end
  end
endmodule

// File: rtl/rdo_addr_dec_chk.sv
module rdo_addr_dec_chk #(
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          strobe_i,
  input logic          ack_o,
  input logic          fifo_pop_o,
  input logic [5:0]    am_i,
  input logic [DW-1:0] ctrl_o
);
  p_ack_needs_strobe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_o) |-> $past(strobe_i));

  p_ack_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && !strobe_i) |=> !ack_o);

  p_ack_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && strobe_i) |=> ack_o);

  p_pop_once_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_pop_o |-> !ack_o);

  p_pop_acked_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_pop_o |=> ack_o);

  p_pop_am_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_pop_o |-> (am_i == 6'h39 || am_i == 6'h3D));

  p_ctrl_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> $stable(ctrl_o));
endmodule

bind rdo_addr_dec rdo_addr_dec_chk #(.DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .strobe_i   (strobe_i),
  .ack_o      (ack_o),
  .fifo_pop_o (fifo_pop_o),
  .am_i       (am_i),
  .ctrl_o     (ctrl_o)
);

// File: tb/rdo_addr_dec_test.sv
module rdo_addr_dec_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] sw24 = 13'h0A0;
  logic [4:0]  sw16 = 5'h04;
  logic [3:0]  slot = 4'd3;
  logic [23:0] addr = '0;
  logic [5:0]  am = '0;
  logic        strobe = 1'b0, wr = 1'b0, lw = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ack, pop;
  logic        push = 1'b0;
  logic [31:0] push_val = '0;
  logic [31:0] fdata = '0;
  logic [31:0] ctrl;

  int errors = 0, checks = 0, cycles = 0;

  always #2 clk = ~clk;

  rdo_addr_dec uut (
    .clk_i(clk), .rst_ni(rst_n), .sw_a24_i(sw24), .sw_a16_i(sw16), .slot_i(slot),
    .addr_i(addr), .am_i(am), .strobe_i(strobe), .write_i(wr), .lword_i(lw),
    .wdata_i(wdata), .rdata_o(rdata), .ack_o(ack), .fifo_push_i(push),
    .fifo_data_i(fdata), .fifo_pop_o(pop), .ctrl_o(ctrl)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural target: 0 none, 1 count, 2 fifo, 3 control
  function automatic int model_tgt(input logic [23:0] a, input logic [5:0] m,
                                   input logic l, input logic w);
    int win16, win24, ofs;
    win16 = (int'(a) / 2048) % 32;
    win24 = int'(a) / 2048;
    ofs   = int'(a) % 2048;
    if (m == 6'h2D && win16 == (int'(sw16) + int'(slot)) % 32 && !l && !w && ofs == 0) return 1;
    if ((m == 6'h39 || m == 6'h3D) && l && win24 == (int'(sw24) + int'(slot)) % 8192) begin
      if (ofs == 0 && !w) return 2;
      if (ofs == 4) return 3;
    end
    return 0;
  endfunction

  logic [31:0] q[$];
  int          m_count;
  logic        m_ack;
  logic [31:0] m_rdata, m_ctrl;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      m_count <= 0; m_ack <= 1'b0; m_rdata <= '0; m_ctrl <= '0; fdata <= '0;
    end else begin
      int  t;
      bit  take, mpop;
      t    = model_tgt(addr, am, lw, wr);
      take = strobe && !m_ack && t != 0;
      mpop = take && t == 2 && m_count > 0;
      if (mpop) void'(q.pop_front());
      if (push) q.push_back(push_val);
      m_count <= m_count + int'(push) - int'(mpop);
      if (take) begin
        case (t)
          1: m_rdata <= 32'(m_count);
          2: m_rdata <= mpop ? fdata : 32'h0;
          default: begin
            m_rdata <= wr ? 32'h0 : m_ctrl;
            if (wr) m_ctrl <= wdata;
          end
        endcase
      end
      m_ack <= strobe && (m_ack || take);
      fdata <= (q.size() > 0) ? q[0] : 32'h0;
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      bit exp_pop;
      exp_pop = strobe && !m_ack && model_tgt(addr, am, lw, wr) == 2 && m_count > 0;
      check(ack == m_ack, "R8 ack timing", 32'(ack), 32'(m_ack));
      check(pop == exp_pop, "R3 pop pulse", 32'(pop), 32'(exp_pop));
      check(ctrl == m_ctrl, "R4 ctrl_o", ctrl, m_ctrl);
      if (m_ack) check(rdata == m_rdata, "R2 R3 rdata", rdata, m_rdata);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic push_word(input logic [31:0] v);
    @(posedge clk); #1;
    push = 1'b1; push_val = v;
    @(posedge clk); #1;
    push = 1'b0;
  endtask

  task automatic bus(input logic [23:0] a, input logic [5:0] m, input logic l,
                     input logic w, input logic [31:0] wd, input bit push_too,
                     input logic [31:0] pv, input int hold,
                     output bit acked, output logic [31:0] rd);
    @(posedge clk); #1;
    addr = a; am = m; lw = l; wr = w; wdata = wd; strobe = 1'b1;
    if (push_too) begin push = 1'b1; push_val = pv; end
    acked = 1'b0; rd = '0;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1;
      push = 1'b0;
      if (ack) begin acked = 1'b1; rd = rdata; break; end
    end
    for (int i = 0; i < hold; i++) begin @(posedge clk); #1; end
    strobe = 1'b0;
    @(posedge clk); #1;
    @(posedge clk); #1;
  endtask

  localparam logic [23:0] A24B = 24'h051800;  // (0x0A0+3)*2048
  localparam logic [23:0] A16B = 24'h003800;  // (4+3)*2048

  initial begin
    bit          ok;
    logic [31:0] d;
    repeat (3) @(posedge clk);
    #1;
    check(ack == 1'b0 && pop == 1'b0, "R9 reset ack/pop", {ack, pop}, 0);
    check(ctrl == 32'h0, "R9 reset ctrl", ctrl, 0);
    rst_n = 1'b1;

    bus(A16B, 6'h2D, 0, 0, 0, 0, 0, 0, ok, d);
    check(ok && d == 0, "R9 R2 count after reset", d, 0);

    push_word(32'h1111_AAAA); push_word(32'h2222_BBBB); push_word(32'h3333_CCCC);
    bus(A16B, 6'h2D, 0, 0, 0, 0, 0, 0, ok, d);
    check(ok && d == 3, "R7 R2 count after pushes", d, 3);

    bus(A24B, 6'h39, 1, 0, 0, 0, 0, 0, ok, d);
    check(ok && d == 32'h1111_AAAA, "R3 fifo word 1", d, 32'h1111_AAAA);
    bus(A24B, 6'h3D, 1, 0, 0, 0, 0, 0, ok, d);
    check(ok && d == 32'h2222_BBBB, "R3 fifo word 2", d, 32'h2222_BBBB);

    // R8: long hold pops once
    bus(A24B, 6'h39, 1, 0, 0, 0, 0, 5, ok, d);
    check(ok && d == 32'h3333_CCCC, "R8 held read data", d, 32'h3333_CCCC);
    bus(A16B, 6'h2D, 0, 0, 0, 0, 0, 0, ok, d);
    check(ok && d == 0, "R8 single pop per strobe", d, 0);

    bus(A24B, 6'h39, 1, 0, 0, 0, 0, 0, ok, d);
    check(ok && d == 0, "R3 empty read acked zero", {31'b0, ok} ^ d, 1);

    bus(A24B + 4, 6'h3D, 1, 1, 32'hDEAD_BEEF, 0, 0, 0, ok, d);
    check(ok && ctrl == 32'hDEAD_BEEF, "R4 ctrl write", ctrl, 32'hDEAD_BEEF);
    bus(A24B + 4, 6'h39, 1, 0, 0, 0, 0, 0, ok, d);
    check(ok && d == 32'hDEAD_BEEF, "R4 ctrl read", d, 32'hDEAD_BEEF);

    push_word(32'h4444_DDDD);
    bus(A24B, 6'h09, 1, 0, 0, 0, 0, 0, ok, d);
    check(!ok, "R5 A32 modifier ignored", 32'(ok), 0);
    bus(A16B + 4, 6'h2D, 0, 0, 0, 0, 0, 0, ok, d);
    check(!ok, "R5 A16 data region ignored", 32'(ok), 0);
    bus(A16B, 6'h29, 0, 0, 0, 0, 0, 0, ok, d);
    check(!ok, "R5 other A16 modifier ignored", 32'(ok), 0);
    bus(A24B + 4, 6'h0D, 1, 1, 32'h1234_5678, 0, 0, 0, ok, d);
    check(!ok && ctrl == 32'hDEAD_BEEF, "R5 ctrl untouched", ctrl, 32'hDEAD_BEEF);
    bus(A24B + 24'h800, 6'h39, 1, 0, 0, 0, 0, 0, ok, d);
    check(!ok, "R1 neighbour window ignored", 32'(ok), 0);
    bus(A24B, 6'h39, 0, 0, 0, 0, 0, 0, ok, d);
    check(!ok, "R6 16-bit fifo read ignored", 32'(ok), 0);
    bus(A24B, 6'h39, 1, 1, 32'h5, 0, 0, 0, ok, d);
    check(!ok, "R6 fifo write ignored", 32'(ok), 0);
    bus(A16B, 6'h2D, 0, 1, 32'h9, 0, 0, 0, ok, d);
    check(!ok, "R6 count write ignored", 32'(ok), 0);
    bus(A24B + 8, 6'h39, 1, 0, 0, 0, 0, 0, ok, d);
    check(!ok, "R6 unmapped offset ignored", 32'(ok), 0);
    bus(A16B, 6'h2D, 0, 0, 0, 0, 0, 0, ok, d);
    check(ok && d == 1, "R5 R6 count unchanged by misses", d, 1);

    // same-edge push and pop
    bus(A24B, 6'h3D, 1, 0, 0, 1, 32'h5555_EEEE, 0, ok, d);
    check(ok && d == 32'h4444_DDDD, "R7 pop with push data", d, 32'h4444_DDDD);
    bus(A16B, 6'h2D, 0, 0, 0, 0, 0, 0, ok, d);
    check(ok && d == 1, "R7 push+pop net zero", d, 1);
    // count read coincident with push returns old value
    bus(A16B, 6'h2D, 0, 0, 0, 1, 32'h6666_FFFF, 0, ok, d);
    check(ok && d == 1, "R2 count read sees pre-push value", d, 1);
    bus(A16B, 6'h2D, 0, 0, 0, 0, 0, 0, ok, d);
    check(ok && d == 2, "R7 count after push", d, 2);

    // slot move
    slot = 4'd4;
    bus(A24B, 6'h39, 1, 0, 0, 0, 0, 0, ok, d);
    check(!ok, "R1 old slot window ignored", 32'(ok), 0);
    bus(A24B + 24'h800, 6'h39, 1, 0, 0, 0, 0, 0, ok, d);
    check(ok && d == 32'h5555_EEEE, "R1 new slot window", d, 32'h5555_EEEE);
    bus(A16B + 24'h800, 6'h2D, 0, 0, 0, 0, 0, 0, ok, d);
    check(ok && d == 1, "R1 R2 A16 window follows slot", d, 1);

    repeat (3) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule